// File: doc/BRIEF.md
# Hash Message Word Ingress Packer

This block sits on the data write port of a hash accelerator. Software or a DMA engine writes the message as 32-bit words to a single address. The write port carries no per-byte valid mask. Each word passes through one of four fixed byte-lane permutations, and the block then sends it to the hash core as a byte stream with a valid/ready handshake. The block works out where the message ends from its own state. A start pulse loads a 64-bit message length given in bits, and a byte counter counts it down. The last word of the message is cut short so that only the real bytes leave the block, and the final byte carries a last flag.

The control logic is a five-state machine. IDLE means no message is configured. ARM waits out the settle window after the start pulse. RECV waits for the next data word. EMIT shifts the bytes of the held word out. DONE means the message is complete.

The transitions are as follows:
- A start pulse moves any state to ARM, or to DONE when the length holds no whole byte.
- ARM moves to RECV after the settle window ends.
- RECV moves to EMIT when a word is written.
- EMIT moves back to RECV after the fourth byte of a word, or to DONE after the last message byte.
- A soft reset returns any state to IDLE.

A word written in IDLE, ARM or DONE is dropped, and the block raises a one-cycle write-error pulse.

Top module: `hash_word_packer`

## Requirements
- R1: After the reset input or the soft reset, the block is in IDLE. In IDLE `out_valid`, `out_last`, `msg_done` and `wr_err` are 0 and `wr_ready` is 1.
- R2: A start pulse loads the byte count as `cfg_bitlen[63:3]`. The low three bits are ignored. The count may be as large as 2^61-1 bytes, and a long message never ends early.
- R3: A word accepted on either of the first two clock edges after the start edge is dropped. It produces no output byte, and `wr_err` is 1 in the cycle after that edge.
- R4: Write the word bytes as b0 = bits 7:0 up to b3 = bits 31:24. The bytes leave the block in an order set by `cfg_order`, captured at start: 0 gives b0,b1,b2,b3; 1 gives b3,b2,b1,b0; 2 gives b0,b1,b3,b2; 3 gives b2,b3,b0,b1.
- R5: Each accepted word produces 4 output bytes. The exception is the word that reaches the end of the message, which produces only as many bytes as remain in the count, in the R4 order.
- R6: `out_last` is 1 on the final message byte and on no other byte. After that byte is taken, `msg_done` stays 1 until the next start pulse or soft reset.
- R7: A start pulse with a byte count of zero gives `msg_done` = 1 in the cycle after the start edge, and no byte is emitted.
- R8: A word written while `msg_done` is 1 is dropped, emits no byte, and raises `wr_err` for exactly one cycle.
- R9: A word written in IDLE is dropped, emits no byte, and raises `wr_err` for one cycle.
- R10: `wr_ready` is 0 while a byte is pending on the output. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R11: A soft reset aborts a message in progress. It clears the byte count, the byte order and `msg_done`, and a later word is dropped as in R9.
- R12: A start pulse during a message abandons it, and the new message then runs from its own length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear back to IDLE |
| start | input | 1 | Load length and byte order, begin a message |
| cfg_order | input | 2 | Byte-order mode, captured on start |
| cfg_bitlen | input | 64 | Message length in bits, captured on start |
| wr_valid | input | 1 | Message word written |
| wr_data | input | 32 | Message word |
| wr_ready | output | 1 | Word can be taken this cycle |
| wr_err | output | 1 | One-cycle pulse: a word was dropped |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Hash core takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the message |
| msg_done | output | 1 | Message complete |

## Verification
The bench aims at the edges of the message.
- It uses lengths that end one, two or three bytes into a word. A packer that always sent whole words would show up as extra bytes in the scoreboard, and one with an off-by-one counter would put the last flag on the wrong byte.
- Words are written in the two cycles just after start. A design with a short settle window would hash them instead of raising the error.
- A zero-length start checks for a design that would hang in ARM.
- Writes after completion and a length above 2^32 bytes check that trailing words are dropped and that a truncated counter does not end the message early.
- Every byte-order mode runs with the output stalled in a toggling pattern, which exposes a wrong lane table or a byte lost during a stall.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = LANES * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RECV,
        ST_EMIT,
        ST_DONE
    } hwp_state_e;

    typedef enum logic [1:0] {
        ORD_PASS  = 2'd0,
        ORD_SWAP  = 2'd1,
        ORD_HIGH  = 2'd2,
        ORD_HALF  = 2'd3
    } hwp_order_e;

endpackage

// File: rtl/hwp_lane_perm.sv
module hwp_lane_perm
    import hwp_pkg::*;
(
    input  hwp_order_e          order,
    input  logic [WORD_W-1:0]   din,
    output logic [WORD_W-1:0]   dout
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] IDX = 2'(i);
        logic [1:0] src;

        always_comb begin
            unique case (order)
                ORD_PASS: src = IDX;
                ORD_SWAP: src = ~IDX;
                ORD_HIGH: src = IDX[1] ? (IDX ^ 2'b01) : IDX;
                ORD_HALF: src = IDX ^ 2'b10;
                default:  src = IDX;
            endcase
        end

        assign dout[BYTE_W*i +: BYTE_W] = din[BYTE_W*src +: BYTE_W];
    end

endmodule

// File: rtl/hwp_len_counter.sv
module hwp_len_counter #(
    parameter int unsigned CNT_W = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_one
);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clr) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && (rem_q != '0)) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign is_one = (rem_q == CNT_W'(1));

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr && (rem_q != '0)) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

    // R11
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem_q == '0));

endmodule

// File: rtl/hash_word_packer.sv
module hash_word_packer
    import hwp_pkg::*;
#(
    parameter int unsigned LEN_W  = 64,
    parameter int unsigned SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic [1:0]        cfg_order,
    input  logic [LEN_W-1:0]  cfg_bitlen,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    output logic              wr_ready,
    output logic              wr_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              msg_done
);

    localparam int unsigned CNT_W = LEN_W - 3;
    localparam int unsigned SC_W  = (SETTLE < 2) ? 1 : $clog2(SETTLE);
    localparam int unsigned LN_W  = $clog2(LANES);

    hwp_state_e        state_q, state_d;
    hwp_order_e        order_q;
    logic [SC_W-1:0]   sc_q;
    logic [LN_W-1:0]   lane_q;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] perm_w;
    logic              fire;
    logic              last_byte;
    logic              zero_len;

    assign zero_len = (cfg_bitlen[LEN_W-1:3] == '0);
    assign fire     = out_valid && out_ready;

    hwp_lane_perm u_perm (
        .order (order_q),
        .din   (wr_data),
        .dout  (perm_w)
    );

    hwp_len_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .load     (start),
        .load_val (cfg_bitlen[LEN_W-1:3]),
        .dec      (fire),
        .is_one   (last_byte)
    );

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = zero_len ? ST_DONE : ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ARM:  if (sc_q == SC_W'(SETTLE - 1)) state_d = ST_RECV;
                ST_RECV: if (wr_valid) state_d = ST_EMIT;
                ST_EMIT: begin
                    if (fire && last_byte)
                        state_d = ST_DONE;
                    else if (fire && (lane_q == LN_W'(LANES - 1)))
                        state_d = ST_RECV;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            order_q <= ORD_PASS;
            sc_q    <= '0;
            lane_q  <= '0;
            hold_q  <= '0;
            wr_err  <= 1'b0;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
            order_q <= ORD_PASS;
            sc_q    <= '0;
            lane_q  <= '0;
            hold_q  <= '0;
            wr_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            wr_err  <= wr_valid && wr_ready && (state_q != ST_RECV);
            if (start) begin
                order_q <= hwp_order_e'(cfg_order);
                sc_q    <= '0;
            end else if (state_q == ST_ARM) begin
                sc_q <= sc_q + SC_W'(1);
            end
            if ((state_q == ST_RECV) && wr_valid && !start) begin
                hold_q <= perm_w;
                lane_q <= '0;
            end else if (fire) begin
                hold_q <= hold_q >> BYTE_W;
                lane_q <= lane_q + LN_W'(1);
            end
        end
    end

    always_comb begin
        wr_ready  = (state_q != ST_EMIT);
        out_valid = (state_q == ST_EMIT);
        out_data  = hold_q[BYTE_W-1:0];
        out_last  = (state_q == ST_EMIT) && last_byte;
        msg_done  = (state_q == ST_DONE);
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

    // R10
    no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_ready);

    // R6
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (fire && out_last && !start) |=> msg_done);

    // R8
    late_word_err_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wr_valid && msg_done) |=> wr_err);

    // R3
    settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wr_valid && (state_q == ST_ARM)) |=> (wr_err && !out_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!out_valid && !msg_done && wr_ready));

endmodule

// File: tb/hash_word_packer_test.sv
module hash_word_packer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_order = 2'd0;
    logic [63:0] cfg_bitlen = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        wr_err;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_last;
    logic        msg_done;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    bit          stall_en = 1'b0;
    int unsigned tick = 0;
    logic [8:0]  exp_q[$];
    longint unsigned exp_rem = 0;
    int          exp_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        tick <= tick + 1;
    end
    assign out_ready = !stall_en || (tick % 3 != 1);

    hash_word_packer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .start      (start),
        .cfg_order  (cfg_order),
        .cfg_bitlen (cfg_bitlen),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .wr_err     (wr_err),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .msg_done   (msg_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard compare of every byte taken (R4 R5 R6)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5/R8: actual byte %0h last %0b, expected no byte", out_data, out_last);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({out_last, out_data} !== e) begin
                    n_fail++;
                    $display("FAIL R4/R6: actual %0h expected %0h", {out_last, out_data}, e);
                end
            end
        end
    end

    function automatic logic [7:0] emit_byte(input logic [31:0] w, input int mode, input int k);
        int idx;
        case (mode)
            0: idx = k;
            1: idx = 3 - k;
            2: idx = (k < 2) ? k : 5 - k;
            default: idx = (k + 2) % 4;
        endcase
        return w[8*idx +: 8];
    endfunction

    task automatic do_start(input longint unsigned bits, input int mode);
        start = 1'b1;
        cfg_bitlen = bits;
        cfg_order = 2'(mode);
        exp_rem = bits >> 3;
        exp_mode = mode;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) begin
            if (exp_rem > 0) begin
                exp_q.push_back({exp_rem == 1, emit_byte(w, exp_mode, k)});
                exp_rem--;
            end
        end
        wr_valid = 1'b1;
        wr_data = w;
        for (int g = 0; g < 500; g++) begin
            if (wr_ready) begin
                @(posedge clk); #1;
                break;
            end
            @(posedge clk); #1;
        end
        wr_valid = 1'b0;
    endtask

    task automatic drop_word(input logic [31:0] w, input string req);
        wr_valid = 1'b1;
        wr_data = w;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        chk(wr_err === 1'b1, req, wr_err, 1);
        @(posedge clk); #1;
        chk(wr_err === 1'b0 && !out_valid, req, {out_valid, wr_err}, 0);
    endtask

    task automatic drain();
        for (int g = 0; g < 2000; g++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic run_msg(input longint unsigned bits, input int mode, input int seed);
        longint unsigned nb;
        nb = bits >> 3;
        do_start(bits, mode);
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < int'((nb + 3) / 4); i++)
            send_word(32'h9E3779B9 * (i + seed) ^ 32'h5A17C3E1);
        drain();
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        chk(msg_done === 1'b1, "R6", msg_done, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(!out_valid && !out_last && !msg_done && !wr_err && wr_ready, "R1",
            {out_valid, out_last, msg_done, wr_err, wr_ready}, 5'b00001);

        // R9 word in IDLE
        drop_word(32'hDEADBEEF, "R9");

        // R3 settle window: two early words dropped, then a real message
        do_start(64'd64, 0);
        wr_valid = 1'b1;
        wr_data = 32'h11223344;
        @(posedge clk); #1;
        chk(wr_err === 1'b1 && !out_valid, "R3", wr_err, 1);
        @(posedge clk); #1;
        chk(wr_err === 1'b1 && !out_valid, "R3", wr_err, 1);
        wr_valid = 1'b0;
        send_word(32'hA1B2C3D4);
        send_word(32'h0F1E2D3C);
        drain();
        chk(msg_done === 1'b1, "R6", msg_done, 1);

        // R8 word after completion
        drop_word(32'hCAFEF00D, "R8");
        chk(msg_done === 1'b1, "R8", msg_done, 1);

        // R4 R5 each mode, lengths ending mid-word, R2 low bits ignored
        run_msg(64'd80, 0, 1);
        run_msg(64'd47, 1, 7);
        run_msg(64'd56, 2, 3);
        run_msg(64'd72, 3, 9);
        // R10 stalled output in every mode
        stall_en = 1'b1;
        run_msg(64'd104, 0, 4);
        run_msg(64'd88, 1, 5);
        run_msg(64'd32, 2, 6);
        run_msg(64'd8, 3, 2);
        stall_en = 1'b0;

        // R7 zero length (bits below one byte)
        do_start(64'd7, 1);
        chk(msg_done === 1'b1 && !out_valid, "R7", msg_done, 1);
        @(posedge clk); #1;
        chk(!out_valid, "R7", out_valid, 0);

        // R12 restart mid-message
        do_start(64'd96, 0);
        repeat (2) @(posedge clk);
        #1;
        send_word(32'h01020304);
        drain();
        chk(msg_done === 1'b0, "R12", msg_done, 0);
        run_msg(64'd24, 1, 11);

        // R2 long length: bytes 2^37, no early end
        do_start(64'h0000_0100_0000_0000, 2);
        repeat (2) @(posedge clk);
        #1;
        send_word(32'h55667788);
        drain();
        chk(msg_done === 1'b0 && wr_ready === 1'b1, "R2", {msg_done, wr_ready}, 2'b01);

        // R11 soft reset mid-message
        send_word(32'h99AABBCC);
        soft_rst = 1'b1;
        @(posedge clk); #1;
        soft_rst = 1'b0;
        exp_q.delete();
        chk(!out_valid && !msg_done && wr_ready, "R11", {out_valid, msg_done, wr_ready}, 3'b001);
        drop_word(32'h12345678, "R11");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule